// File: doc/BRIEF.md
# Receive ADC-to-Downconverter Input Router

This block is a register-controlled crossbar in a receive chain. Four ADC sample streams share one valid strobe. The router selects, for each of four downconverter channels, which ADC feeds the channel's in-phase input and which feeds its quadrature input. A quadrature input may instead be held at constant zero, which suits real-only sampling. The routed samples leave through registers, so every routed bus changes on the same clock edge.

Software writes a 32-bit routing word through a one-cycle write strobe. The block checks the word before it keeps it. An illegal word raises an error flag and is dropped, and the routing already in use stays in force. A legal word waits in a shadow register. It moves into the active routing only on a clock edge where the ADC valid strobe is low, so no delivered sample set is split between an old routing and a new one.

Top module: `adc_input_router`

## Requirements
- R1: The routing word holds eight 4-bit selector fields. The in-phase selector of channel c sits at bits [8c+3:8c] and the quadrature selector at bits [8c+7:8c+4]. An in-phase selector value k in 0..3 routes ADC k to that channel's in-phase output.
- R2: A quadrature selector value k in 0..3 routes ADC k to that channel's quadrature output. When all four quadrature selectors hold 0xF, every quadrature output delivers zero.
- R3: A written word is illegal if any in-phase selector is above 3, if any quadrature selector is in 4..14, or if some but not all quadrature selectors are 0xF. Such a word sets cfgError on the clock after the write and leaves the routing unchanged.
- R4: A legal write clears cfgError on the clock after the write.
- R5: A legal word takes effect only after a clock edge at which it is pending and adcValid is low. Samples captured while adcValid stays high keep the old routing.
- R6: chanValid equals adcValid delayed by one clock. The routed outputs are loaded only on edges where adcValid is high and hold their value otherwise.
- R7: After reset, the routed outputs are zero and chanValid and cfgError are low. The active routing is 0x32103210: channel c takes its in-phase input from ADC (2c mod 4) and its quadrature input from ADC (2c+1 mod 4).
- R8: If several legal words are written before an apply opportunity, the last one written is the one applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Routing word write strobe |
| cfgWrData | input | 32 | Routing word |
| adcData | input | 4*SAMPLE_W | ADC samples, ADC k at bits [k*SAMPLE_W +: SAMPLE_W] |
| adcValid | input | 1 | Shared sample valid |
| chanI | output | 4*SAMPLE_W | In-phase outputs, channel c at [c*SAMPLE_W +: SAMPLE_W] |
| chanQ | output | 4*SAMPLE_W | Quadrature outputs, same layout |
| chanValid | output | 1 | Routed sample valid |
| cfgError | output | 1 | Most recent write was illegal |

## Verification
The error flag is due one clock after the write edge. A legal word reaches the active routing on the first later edge with adcValid low. A sample captured on the edge after that appears on the outputs one clock after its own valid edge. The bench drives inputs on falling edges and samples on the falling edge that follows each rising edge, so every check falls in the exact cycle the requirement names. It also counts out a stream held valid across a pending write, to confirm that the switch waits for the first idle edge.

// File: rtl/adc_router_pkg.sv
package adc_router_pkg;
  localparam int NUM_ADC = 4;
  localparam int NUM_CH  = 4;
  localparam int FIELD_W = 4;
  localparam int CFG_W   = 2 * NUM_CH * FIELD_W;
  localparam int SEL_W   = $clog2(NUM_ADC);

  localparam logic [FIELD_W-1:0] ZERO_CODE = '1;
  localparam logic [FIELD_W-1:0] ADC_LIMIT = FIELD_W'(NUM_ADC);
  localparam logic [CFG_W-1:0]   RESET_ROUTE = 32'h3210_3210;

  typedef struct packed {
    logic             loadSample;
    logic             zeroQ;
    logic [CFG_W-1:0] route;
  } routeCtrl_t;

  function automatic logic [FIELD_W-1:0] iField(input logic [CFG_W-1:0] w, input int c);
    return w[2*c*FIELD_W +: FIELD_W];
  endfunction

  function automatic logic [FIELD_W-1:0] qField(input logic [CFG_W-1:0] w, input int c);
    return w[(2*c+1)*FIELD_W +: FIELD_W];
  endfunction
endpackage

// File: rtl/adc_router_ctrl.sv
module adc_router_ctrl
  import adc_router_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             adcValid,
  output routeCtrl_t       ctrl,
  output logic             cfgError
);
  logic [CFG_W-1:0]  shadowWord, activeWord;
  logic              shadowZeroQ, activeZeroQ, pending;
  logic [NUM_CH-1:0] qIsZero, fieldBad;
  logic              wordZeroQ, wordLegal, applyNow;

  // Selector legality (R3): in-phase must name an ADC; quadrature names an ADC or the zero code
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      qIsZero[c]  = (qField(cfgWrData, c) == ZERO_CODE);
      fieldBad[c] = (iField(cfgWrData, c) >= ADC_LIMIT) ||
                    (!qIsZero[c] && (qField(cfgWrData, c) >= ADC_LIMIT));
    end
    wordZeroQ = &qIsZero;
    wordLegal = !(|fieldBad) && (wordZeroQ || !(|qIsZero));
  end

  // Switch only at a sample gap (R5)
  assign applyNow = pending && !adcValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowWord  <= RESET_ROUTE;
      activeWord  <= RESET_ROUTE;
      shadowZeroQ <= 1'b0;
      activeZeroQ <= 1'b0;
      pending     <= 1'b0;
      cfgError    <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        cfgError <= !wordLegal;
        if (wordLegal) begin
          shadowWord  <= cfgWrData;
          shadowZeroQ <= wordZeroQ;
        end
      end
      if (applyNow) begin
        activeWord  <= shadowWord;
        activeZeroQ <= shadowZeroQ;
      end
      if (cfgWrEn && wordLegal) pending <= 1'b1;
      else if (applyNow)        pending <= 1'b0;
    end
  end

  always_comb begin
    ctrl.loadSample = adcValid;
    ctrl.zeroQ      = activeZeroQ;
    ctrl.route      = activeWord;
  end
endmodule

// File: rtl/adc_router_datapath.sv
module adc_router_datapath
  import adc_router_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  routeCtrl_t                 ctrl,
  input  logic [NUM_ADC*SAMPLE_W-1:0] adcData,
  output logic [NUM_CH*SAMPLE_W-1:0]  chanI,
  output logic [NUM_CH*SAMPLE_W-1:0]  chanQ,
  output logic                       chanValid
);
  logic [SAMPLE_W-1:0] adcLane [NUM_ADC];
  logic [SAMPLE_W-1:0] iReg [NUM_CH];
  logic [SAMPLE_W-1:0] qReg [NUM_CH];

  for (genvar k = 0; k < NUM_ADC; k++) begin : g_lane
    assign adcLane[k] = adcData[k*SAMPLE_W +: SAMPLE_W];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SEL_W-1:0] selI, selQ;
    assign selI = ctrl.route[2*c*FIELD_W +: SEL_W];
    assign selQ = ctrl.route[(2*c+1)*FIELD_W +: SEL_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        iReg[c] <= '0;
        qReg[c] <= '0;
      end else if (ctrl.loadSample) begin
        iReg[c] <= adcLane[selI];
        qReg[c] <= ctrl.zeroQ ? '0 : adcLane[selQ];
      end
    end

    assign chanI[c*SAMPLE_W +: SAMPLE_W] = iReg[c];
    assign chanQ[c*SAMPLE_W +: SAMPLE_W] = qReg[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chanValid <= 1'b0;
    else       chanValid <= ctrl.loadSample;
  end
endmodule

// File: rtl/adc_input_router.sv
module adc_input_router
  import adc_router_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [CFG_W-1:0]            cfgWrData,
  input  logic [NUM_ADC*SAMPLE_W-1:0] adcData,
  input  logic                        adcValid,
  output logic [NUM_CH*SAMPLE_W-1:0]  chanI,
  output logic [NUM_CH*SAMPLE_W-1:0]  chanQ,
  output logic                        chanValid,
  output logic                        cfgError
);
  routeCtrl_t ctrl;

  adc_router_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .adcValid(adcValid), .ctrl(ctrl), .cfgError(cfgError)
  );

  adc_router_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .adcData(adcData),
    .chanI(chanI), .chanQ(chanQ), .chanValid(chanValid)
  );
endmodule

// File: rtl/adc_input_router_chk.sv
module adc_input_router_chk
  import adc_router_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cfgWrEn,
  input logic                        adcValid,
  input logic [NUM_CH*SAMPLE_W-1:0]  chanI,
  input logic [NUM_CH*SAMPLE_W-1:0]  chanQ,
  input logic                        chanValid,
  input logic                        cfgError
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    adcValid |=> chanValid);

  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rstN)
    !adcValid |=> !chanValid);

  a_r6_hold_on_idle: assert property (@(posedge clk) disable iff (!rstN)
    !adcValid |=> ($stable(chanI) && $stable(chanQ)));

  a_r3_error_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgError));

  a_r7_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!chanValid && !cfgError));
endmodule

bind adc_input_router adc_input_router_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .adcValid(adcValid),
  .chanI(chanI), .chanQ(chanQ), .chanValid(chanValid), .cfgError(cfgError)
);

// File: tb/adc_input_router_tb_top.sv
`timescale 1ns/1ps
module adc_input_router_tb_top;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [31:0]   cfgWrData = '0;
  logic [4*SW-1:0] adcData = '0;
  logic          adcValid = 1'b0;
  logic [4*SW-1:0] chanI, chanQ;
  logic          chanValid, cfgError;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] curWord;

  always #2.5 clk = ~clk;

  adc_input_router #(.SAMPLE_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .adcData(adcData), .adcValid(adcValid), .chanI(chanI), .chanQ(chanQ),
    .chanValid(chanValid), .cfgError(cfgError)
  );

  // {expected error, word}
  localparam bit [32:0] VEC [10] = '{
    {1'b0, 32'h3210_3210},
    {1'b0, 32'h0123_0123},
    {1'b1, 32'h0000_0004},   // I0 = 4
    {1'b0, 32'hF3F2_F1F0},   // all Q zero
    {1'b1, 32'h0000_0050},   // Q0 = 5
    {1'b1, 32'hF3F2_F110},   // mixed zero Q
    {1'b0, 32'h0000_0000},
    {1'b1, 32'hE000_0000},   // Q3 = 14
    {1'b1, 32'hF0F0_F0FF},   // I0 = 15
    {1'b0, 32'h1302_1320}
  };

  function automatic logic [4*SW-1:0] pattern(input int n);
    logic [4*SW-1:0] p;
    for (int k = 0; k < 4; k++) p[k*SW +: SW] = {4'(k+1), 12'(n)};
    return p;
  endfunction

  function automatic logic [8*SW-1:0] expRoute(input logic [31:0] w, input logic [4*SW-1:0] a);
    logic [4*SW-1:0] ei, eq;
    logic allZ;
    allZ = 1'b1;
    for (int c = 0; c < 4; c++) if (w[8*c+4 +: 4] != 4'hF) allZ = 1'b0;
    for (int c = 0; c < 4; c++) begin
      ei[c*SW +: SW] = a[int'(w[8*c +: 2])*SW +: SW];
      eq[c*SW +: SW] = allZ ? '0 : a[int'(w[8*c+4 +: 2])*SW +: SW];
    end
    return {ei, eq};
  endfunction

  task automatic check(input bit ok, input string req, input logic [8*SW-1:0] act, input logic [8*SW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] w);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = w; adcValid = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sampleCheck(input int n, input logic [31:0] w, input string req);
    logic [8*SW-1:0] e;
    adcData = pattern(n); adcValid = 1'b1;
    @(negedge clk);
    adcValid = 1'b0;
    e = expRoute(w, pattern(n));
    check(chanValid && ({chanI, chanQ} == e), req, {chanI, chanQ}, e);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(!chanValid && !cfgError && chanI == '0 && chanQ == '0, "R7 reset outputs",
          {chanI, chanQ}, '0);
    rstN = 1'b1;
    @(negedge clk);
    curWord = 32'h3210_3210;
    sampleCheck(1, curWord, "R7 reset routing");
    @(negedge clk);
    check(!chanValid, "R6 valid drop", {127'd0, chanValid}, '0);

    // table walk: R1 R2 R3 R4
    for (int v = 0; v < 10; v++) begin
      writeCfg(VEC[v][31:0]);
      check(cfgError == VEC[v][32], "R3 R4 error flag", {127'd0, cfgError}, {127'd0, VEC[v][32]});
      if (!VEC[v][32]) curWord = VEC[v][31:0];
      @(negedge clk);   // idle edge applies pending word
      sampleCheck(10 + v, curWord, "R1 R2 routing");
    end

    // R5: write while stream stays valid
    @(negedge clk);
    adcData = pattern(100); adcValid = 1'b1;
    cfgWrEn = 1'b1; cfgWrData = 32'h0000_0000;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check({chanI, chanQ} == expRoute(curWord, pattern(100)), "R5 old routing first",
          {chanI, chanQ}, expRoute(curWord, pattern(100)));
    adcData = pattern(101);
    @(negedge clk);
    check({chanI, chanQ} == expRoute(curWord, pattern(101)), "R5 old routing while valid",
          {chanI, chanQ}, expRoute(curWord, pattern(101)));
    adcValid = 1'b0; adcData = pattern(55);
    @(negedge clk);
    check(!chanValid && {chanI, chanQ} == expRoute(curWord, pattern(101)), "R6 hold on idle",
          {chanI, chanQ}, expRoute(curWord, pattern(101)));
    curWord = 32'h0000_0000;
    sampleCheck(102, curWord, "R5 new routing after gap");

    // R8: two legal writes before an apply chance is used, last wins
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 32'h0123_0123; adcValid = 1'b1; adcData = pattern(120);
    @(negedge clk);
    cfgWrData = 32'h2301_1032;
    @(negedge clk);
    cfgWrEn = 1'b0; adcValid = 1'b0;
    @(negedge clk);
    curWord = 32'h2301_1032;
    sampleCheck(121, curWord, "R8 last write wins");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule